// File: doc/BRIEF.md
# Line Alarm Edge-Latched Status

This block watches four receive-side alarm conditions of a framed T1/E1-style link and turns every change of each condition into a sticky status bit. The four conditions are remote alarm, alarm indication signal (an unframed all-ones pattern, flagged by an upstream qualifier), loss of signal and loss of frame. Each condition owns two latched bits. One is set when the condition comes on and the other when it goes away, so software sees both the onset and the recovery of every alarm as separate interrupt causes.

Three of the condition levels arrive as synchronous inputs. Loss of signal is produced inside the block by a run-length detector on the recovered bit stream. Software clears latched bits by writing ones to their positions. A registered interrupt line reports any latched bit whose enable is set.

Top module: `alarm_edge_status`

## Requirements
- R1: A rising edge of a condition sets its onset bit: status[3] remote alarm, status[2] all-ones alarm, status[1] loss of signal, status[0] loss of frame. The bit is visible one clock after the level changes.
- R2: A falling edge of a condition sets its recovery bit: status[7] remote alarm, status[6] all-ones alarm, status[5] loss of signal, status[4] loss of frame. The bit is visible one clock after the level changes.
- R3: A latched bit stays set until a clock with clr_wr high and the matching clr_mask bit at 1 clears it. Mask bits at 0 leave their status bits unchanged.
- R4: When a new edge and a clear of the same bit fall in the same clock, the bit stays set.
- R5: los_lvl rises after ZERO_RUN (default 192) consecutive valid zero bits. After ZERO_RUN-1 zeros it stays low.
- R6: A valid one bit drops los_lvl at the next clock and restarts the zero count from 0.
- R7: Stream clocks with bit_valid low neither count a zero nor restart the count.
- R8: irq is high one clock after any status bit is set while its irq_en bit is 1. It is low when no enabled bit is set.
- R9: After reset all status bits, irq and los_lvl are 0.
- R10: One level transition yields exactly one set event. A bit cleared while the level is held constant stays clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_valid | input | 1 | Qualifies bit_data for this clock |
| bit_data | input | 1 | Recovered receive bit |
| rai_lvl | input | 1 | Remote alarm condition level |
| ais_lvl | input | 1 | All-ones alarm condition level |
| lof_lvl | input | 1 | Loss of frame condition level |
| clr_wr | input | 1 | Write strobe for clearing latched bits |
| clr_mask | input | 8 | Ones select the status bits to clear |
| irq_en | input | 8 | Per-bit interrupt enables |
| status | output | 8 | Latched edge bits |
| los_lvl | output | 1 | Loss-of-signal condition level |
| irq | output | 1 | Registered interrupt request |

## Verification
Embedded assertions check on every cycle that each rise or fall of a condition level lands in its bit, that a set bit survives any clock without a matching clear, and that an edge wins over a clear. They also check that a valid one bit drops loss of signal, that loss of signal only rises at the full run length, and that the interrupt follows the enabled bits. The directed scenarios show what no single-cycle property shows. They confirm the exact bit position of each alarm and the ZERO_RUN-1 versus ZERO_RUN boundary. They also show that invalid stream clocks are transparent, that a broken run restarts the count, and that a held level does not set a bit again after it has been cleared.

// File: rtl/alm_pkg.sv
package alm_pkg;
  localparam int NCOND = 4;
  localparam int NSTAT = 2 * NCOND;
  // condition index, also the onset bit position; recovery bit is index + NCOND
  localparam int IDX_LOF = 0;
  localparam int IDX_LOS = 1;
  localparam int IDX_AIS = 2;
  localparam int IDX_RAI = 3;
  typedef logic [NSTAT-1:0] stat_t;
  typedef logic [NCOND-1:0] cond_t;
endpackage

// File: rtl/zero_run_los.sv
module zero_run_los #(
  parameter int ZERO_RUN = 192
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_valid,
  input  logic bit_data,
  output logic los_q
);
  localparam int CW = $clog2(ZERO_RUN + 1);
  localparam logic [CW-1:0] RUN_MAX  = CW'(ZERO_RUN);
  localparam logic [CW-1:0] RUN_LAST = CW'(ZERO_RUN - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      los_q <= 1'b0;
    end else if (bit_valid) begin
      if (bit_data) begin
        cnt_q <= '0;
        los_q <= 1'b0;
      end else if (cnt_q != RUN_MAX) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == RUN_LAST) los_q <= 1'b1;
      end
    end
  end

  // R6: a valid one clears loss of signal at the next clock
  p_one_clears_los_r6: assert property (@(posedge clk) disable iff (rst)
    bit_valid && bit_data |=> !los_q);

  // R5: loss of signal only comes on once the full run has been counted
  p_los_full_run_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(los_q) |-> cnt_q == RUN_MAX);

  // R7: an idle stream clock changes nothing
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !bit_valid |=> $stable(los_q));
endmodule

// File: rtl/cond_edge_latch.sv
module cond_edge_latch (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  input  logic clr_rise,
  input  logic clr_fall,
  output logic rise_q,
  output logic fall_q
);
  logic prev_q;
  logic rise_evt;
  logic fall_evt;

  assign rise_evt = lvl & ~prev_q;
  assign fall_evt = ~lvl & prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      prev_q <= lvl;
      if (rise_evt)      rise_q <= 1'b1;
      else if (clr_rise) rise_q <= 1'b0;
      if (fall_evt)      fall_q <= 1'b1;
      else if (clr_fall) fall_q <= 1'b0;
    end
  end

  // R1: onset captured one clock later
  p_rise_sets_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(lvl) |=> rise_q);
  // R2: recovery captured one clock later
  p_fall_sets_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(lvl) |=> fall_q);
  // R3: sticky without a matching clear
  p_rise_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    rise_q && !clr_rise |=> rise_q);
  p_fall_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    fall_q && !clr_fall |=> fall_q);
  // R4: edge beats a simultaneous clear
  p_edge_beats_clear_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(lvl) && clr_rise |=> rise_q);
endmodule

// File: rtl/irq_gen.sv
module irq_gen #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] stat,
  input  logic [W-1:0] en,
  output logic         irq_q
);
  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(stat & en);
  end

  // R8: no enabled cause means no request on the next clock
  p_irq_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (stat & en) == '0 |=> !irq_q);
  p_irq_raise_r8: assert property (@(posedge clk) disable iff (rst)
    (stat & en) != '0 |=> irq_q);
endmodule

// File: rtl/alarm_edge_status.sv
module alarm_edge_status
  import alm_pkg::*;
#(
  parameter int ZERO_RUN = 192
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_valid,
  input  logic             bit_data,
  input  logic             rai_lvl,
  input  logic             ais_lvl,
  input  logic             lof_lvl,
  input  logic             clr_wr,
  input  logic [NSTAT-1:0] clr_mask,
  input  logic [NSTAT-1:0] irq_en,
  output logic [NSTAT-1:0] status,
  output logic             los_lvl,
  output logic             irq
);
  cond_t conds;
  cond_t rise_bits;
  cond_t fall_bits;
  stat_t clr_vec;

  zero_run_los #(.ZERO_RUN(ZERO_RUN)) u_los (
    .clk(clk), .rst(rst), .bit_valid(bit_valid), .bit_data(bit_data), .los_q(los_lvl)
  );

  always_comb begin
    conds          = '0;
    conds[IDX_RAI] = rai_lvl;
    conds[IDX_AIS] = ais_lvl;
    conds[IDX_LOS] = los_lvl;
    conds[IDX_LOF] = lof_lvl;
  end

  assign clr_vec = clr_wr ? clr_mask : '0;

  for (genvar i = 0; i < NCOND; i++) begin : g_cond
    cond_edge_latch u_edge (
      .clk(clk), .rst(rst), .lvl(conds[i]),
      .clr_rise(clr_vec[i]), .clr_fall(clr_vec[i+NCOND]),
      .rise_q(rise_bits[i]), .fall_q(fall_bits[i])
    );
  end

  assign status = {fall_bits, rise_bits};

  irq_gen #(.W(NSTAT)) u_irq (
    .clk(clk), .rst(rst), .stat(status), .en(irq_en), .irq_q(irq)
  );

  // R9: reset leaves everything quiet
  p_reset_clean_r9: assert property (@(posedge clk)
    rst |=> status == '0 && !irq && !los_lvl);
endmodule

// File: tb/alarm_edge_status_test.sv
module alarm_edge_status_test;
  logic clk = 1'b0;
  logic rst, bit_valid, bit_data, rai_lvl, ais_lvl, lof_lvl, clr_wr, irq, los_lvl;
  logic [7:0] clr_mask, irq_en, status;
  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  alarm_edge_status uut (
    .clk(clk), .rst(rst), .bit_valid(bit_valid), .bit_data(bit_data),
    .rai_lvl(rai_lvl), .ais_lvl(ais_lvl), .lof_lvl(lof_lvl),
    .clr_wr(clr_wr), .clr_mask(clr_mask), .irq_en(irq_en),
    .status(status), .los_lvl(los_lvl), .irq(irq)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000 && !done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog expired: actual %0d cycles expected < 100000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic clear_all();
    clr_wr = 1'b1; clr_mask = 8'hFF;
    tick(1);
    clr_wr = 1'b0; clr_mask = 8'h00;
    tick(1);
  endtask

  task automatic send_bits(input int n, input logic b);
    for (int k = 0; k < n; k++) begin
      bit_valid = 1'b1; bit_data = b;
      tick(1);
    end
    bit_valid = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1; bit_valid = 0; bit_data = 0; rai_lvl = 0; ais_lvl = 0; lof_lvl = 0;
    clr_wr = 0; clr_mask = 0; irq_en = 8'hFF;
    tick(3);
    rst = 1'b0;
    tick(1);
    chk("R9 status", status, 8'h00);
    chk("R9 irq", {7'd0, irq}, 8'h00);
    chk("R9 los", {7'd0, los_lvl}, 8'h00);
  endtask

  task automatic t_rise_each();
    rai_lvl = 1; tick(1); chk("R1 rai onset bit3", status, 8'h08); clear_all();
    ais_lvl = 1; tick(1); chk("R1 ais onset bit2", status, 8'h04); clear_all();
    lof_lvl = 1; tick(1); chk("R1 lof onset bit0", status, 8'h01); clear_all();
  endtask

  task automatic t_fall_each();
    rai_lvl = 0; tick(1); chk("R2 rai recovery bit7", status, 8'h80); clear_all();
    ais_lvl = 0; tick(1); chk("R2 ais recovery bit6", status, 8'h40); clear_all();
    lof_lvl = 0; tick(1); chk("R2 lof recovery bit4", status, 8'h10); clear_all();
  endtask

  task automatic t_sticky_w1c();
    lof_lvl = 1; tick(1); lof_lvl = 0; tick(1);
    tick(5);
    chk("R3 sticky both", status, 8'h11);
    clr_wr = 1; clr_mask = 8'h00; tick(1); clr_wr = 0;
    chk("R3 zero mask keeps", status, 8'h11);
    clr_wr = 1; clr_mask = 8'h10; tick(1); clr_wr = 0; clr_mask = 0;
    chk("R3 selective clear", status, 8'h01);
    clear_all();
  endtask

  task automatic t_collision();
    rai_lvl = 1; tick(1); rai_lvl = 0; tick(1);
    chk("R4 setup", status, 8'h88);
    rai_lvl = 1; clr_wr = 1; clr_mask = 8'h08; tick(1);
    clr_wr = 0; clr_mask = 0;
    chk("R4 edge wins", status, 8'h88);
    rai_lvl = 0; tick(1);
    clear_all();
  endtask

  task automatic t_single_event();
    ais_lvl = 1; tick(1);
    clear_all();
    tick(4);
    chk("R10 held level no reset", status, 8'h00);
    ais_lvl = 0; tick(1); clear_all();
  endtask

  task automatic t_los_boundary();
    send_bits(1, 1'b1);
    send_bits(191, 1'b0);
    tick(3);
    chk("R5 191 zeros no los", {7'd0, los_lvl}, 8'h00);
    chk("R5 191 zeros no bit", status, 8'h00);
    send_bits(1, 1'b0);
    chk("R5 192nd zero los", {7'd0, los_lvl}, 8'h01);
    tick(1);
    chk("R1 los onset bit1", status, 8'h02);
    send_bits(1, 1'b1);
    chk("R6 one drops los", {7'd0, los_lvl}, 8'h00);
    tick(1);
    chk("R2 los recovery bit5", status, 8'h22);
    clear_all();
  endtask

  task automatic t_los_break();
    send_bits(150, 1'b0);
    send_bits(1, 1'b1);
    send_bits(191, 1'b0);
    tick(2);
    chk("R6 count restarted", {7'd0, los_lvl}, 8'h00);
    send_bits(1, 1'b1);
    clear_all();
  endtask

  task automatic t_valid_gate();
    send_bits(100, 1'b0);
    bit_valid = 0; bit_data = 1; tick(20); bit_data = 0;
    chk("R7 idle no los", {7'd0, los_lvl}, 8'h00);
    send_bits(92, 1'b0);
    chk("R7 idle ones ignored", {7'd0, los_lvl}, 8'h01);
    send_bits(1, 1'b1);
    tick(1);
    clear_all();
  endtask

  task automatic t_irq();
    irq_en = 8'h00;
    lof_lvl = 1; tick(1); tick(1);
    chk("R8 masked no irq", {7'd0, irq}, 8'h00);
    irq_en = 8'h01; tick(1);
    chk("R8 enabled irq", {7'd0, irq}, 8'h01);
    irq_en = 8'hFE; tick(1);
    chk("R8 other enables no irq", {7'd0, irq}, 8'h00);
    irq_en = 8'hFF;
    clr_wr = 1; clr_mask = 8'h01; tick(1); clr_wr = 0; clr_mask = 0;
    tick(1);
    chk("R8 cleared cause drops irq", {7'd0, irq}, 8'h00);
    lof_lvl = 0; tick(1); clear_all();
  endtask

  initial begin
    t_reset();
    t_rise_each();
    t_fall_each();
    t_sticky_w1c();
    t_collision();
    t_single_event();
    t_los_boundary();
    t_los_break();
    t_valid_gate();
    t_irq();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule